// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block chooses, every clock, the address of the next microinstruction of a microcoded machine. It picks one of five candidates: the constant zero, the direct input bus, its own microprogram counter, its loop register/counter, or the top of an internal return stack. A 4-bit instruction code selects the candidate. The code is combined with a condition test and a test of whether the loop register/counter is zero. The same decode decides whether the return stack is pushed, popped or cleared, and whether the register/counter is held, decremented or loaded.

The address output is combinational from the current instruction, inputs and state. Three active-low select strobes, exactly one low at any time, tell the surrounding logic which external source must drive the direct input bus: the pipeline branch field, the instruction-mapping table or the interrupt vector. The output enable does not tri-state anything. It is brought out as a valid flag beside the address. The return stack holds nine entries, and a full flag warns when all of them are in use.

Top module: `useq_next_addr`

## Requirements
- R1: A condition test passes when `cond_en_n` is 1, or when `cond_en_n` is 0 and `cond_n` is 0. It fails only when `cond_en_n` is 0 and `cond_n` is 1.
- R2: On every clock the microprogram counter loads the current `addr` plus `carry_in`, modulo 2^12. With `carry_in` at 0 the same address repeats.
- R3: Code 0 drives `addr` to 0 and empties the stack. Code 2 drives `din` and pulls `map_en_n` low. Code 6 drives `din` on pass or the counter address on fail, and pulls `vect_en_n` low. Every other code pulls `pipe_en_n` low. Exactly one of the three strobes is low at all times.
- R4: Code 1 drives `din` and pushes the counter address on pass, and drives the counter address without a push on fail. Code 3 drives `din` on pass, otherwise the counter address. Code 7 drives `din` on pass or the register value on fail, with no stack change. Code 5 always pushes the counter address, and drives `din` on pass or the register value on fail.
- R5: Code 4 drives the counter address and always pushes it. It loads the register from `din` only on pass.
- R6: Code 8 with a nonzero register drives the stack top and decrements the register. With a zero register it drives the counter address and pops. Code 9 with a nonzero register drives `din` and decrements. With a zero register it drives the counter address.
- R7: Code 10 drives the stack top and pops on pass. Code 11 drives `din` and pops on pass. On fail both drive the counter address and leave the stack alone. Code 13 drives the stack top on fail, or the counter address with a pop on pass.
- R8: Code 12 drives the counter address and loads the register from `din`. Code 14 drives the counter address with no other effect.
- R9: Code 15 on fail with a nonzero register drives the stack top and decrements. On fail with a zero register it drives `din` and pops. On pass it drives the counter address and pops, and decrements only when the register is nonzero.
- R10: With `reg_load_n` at 0 the register loads `din` on the clock edge, whatever hold or decrement the instruction asks for.
- R11: The stack holds 9 entries. `full_n` is 0 exactly when 9 entries are held. A push onto a full stack overwrites the top entry and leaves the depth at 9. A pop from an empty stack leaves the depth at 0.
- R12: A synchronous active-high `rst` clears the microprogram counter, the register and the stack depth.
- R13: `addr_valid` equals the inverse of `out_en_n`.
- R14: A loop whose register is preloaded with N and closed by code 8 or code 9 runs its body N+1 times: N branches back, then one fall-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 4 | Next-address instruction code |
| cond_n | input | 1 | Condition under test, low means true |
| cond_en_n | input | 1 | Condition test enable, high forces a pass |
| reg_load_n | input | 1 | Forces a register load from `din` when low |
| out_en_n | input | 1 | Output enable, low marks the address valid |
| carry_in | input | 1 | Increment applied to the address for the counter |
| din | input | 12 | Direct address / count input |
| addr | output | 12 | Next microinstruction address |
| addr_valid | output | 1 | Address qualifier from `out_en_n` |
| full_n | output | 1 | Low when the stack holds 9 entries |
| pipe_en_n | output | 1 | Selects the pipeline branch field onto `din` |
| map_en_n | output | 1 | Selects the mapping table onto `din` |
| vect_en_n | output | 1 | Selects the vector source onto `din` |

## Verification
The loop tests preload counts of 2 and 3 and count the branches back. A design that tests for zero after decrementing, rather than before, would run one pass short of N+1 times. The stack tests push ten times. They check that the tenth push replaced the ninth entry and did not land beyond it, and that a pop on an empty stack leaves the depth at zero, not wrapped, which would shift the point where `full_n` falls. The three-way branch is driven through all three of its exits. A design that decremented a zero register on the pass exit would show a wrapped count on the next register read. The load override is applied during a decrementing instruction, where a design that gave the instruction priority would keep the decremented value.

// File: rtl/useq_pkg.sv
`timescale 1ns/1ps
package useq_pkg;

  typedef enum logic [2:0] {
    SRC_ZERO,
    SRC_DIN,
    SRC_UPC,
    SRC_REG,
    SRC_TOS
  } src_e;

  typedef enum logic [1:0] {
    STK_HOLD,
    STK_PUSH,
    STK_POP,
    STK_CLEAR
  } stk_e;

  typedef enum logic [1:0] {
    CNT_HOLD,
    CNT_DEC,
    CNT_LOAD
  } cnt_e;

  typedef enum logic [1:0] {
    EN_PIPE,
    EN_MAP,
    EN_VECT
  } ensel_e;

  localparam int NUM_EN = 3;

  typedef enum logic [3:0] {
    OP_GO_ZERO    = 4'd0,
    OP_CALL_D     = 4'd1,
    OP_MAP        = 4'd2,
    OP_JUMP_D     = 4'd3,
    OP_PUSH_LD    = 4'd4,
    OP_CALL_RD    = 4'd5,
    OP_VEC_JUMP   = 4'd6,
    OP_JUMP_RD    = 4'd7,
    OP_RPT_STACK  = 4'd8,
    OP_RPT_DIN    = 4'd9,
    OP_RETURN     = 4'd10,
    OP_JUMP_POP   = 4'd11,
    OP_LOAD_CNT   = 4'd12,
    OP_TEST_END   = 4'd13,
    OP_NEXT       = 4'd14,
    OP_BRANCH3    = 4'd15
  } op_e;

  typedef struct packed {
    src_e   src;
    stk_e   stk;
    cnt_e   cnt;
    ensel_e en;
  } ctl_t;

  // condition passes unless the test is enabled and the condition is false
  function automatic logic test_pass(input logic cc_n, input logic cc_en_n);
    return cc_en_n | ~cc_n;
  endfunction

endpackage

// File: rtl/useq_decode.sv
`timescale 1ns/1ps
module useq_decode
  import useq_pkg::*;
(
  input  logic [3:0] op_i,
  input  logic       pass_i,
  input  logic       zero_i,
  output ctl_t       ctl_o
);

  always_comb begin
    ctl_o.src = SRC_UPC;
    ctl_o.stk = STK_HOLD;
    ctl_o.cnt = CNT_HOLD;
    ctl_o.en  = EN_PIPE;
    case (op_e'(op_i))
      OP_GO_ZERO: begin
        ctl_o.src = SRC_ZERO;
        ctl_o.stk = STK_CLEAR;
      end
      OP_CALL_D: begin
        if (pass_i) begin
          ctl_o.src = SRC_DIN;
          ctl_o.stk = STK_PUSH;
        end
      end
      OP_MAP: begin
        ctl_o.src = SRC_DIN;
        ctl_o.en  = EN_MAP;
      end
      OP_JUMP_D: begin
        if (pass_i) ctl_o.src = SRC_DIN;
      end
      OP_PUSH_LD: begin
        ctl_o.stk = STK_PUSH;
        if (pass_i) ctl_o.cnt = CNT_LOAD;
      end
      OP_CALL_RD: begin
        ctl_o.stk = STK_PUSH;
        ctl_o.src = pass_i ? SRC_DIN : SRC_REG;
      end
      OP_VEC_JUMP: begin
        ctl_o.en = EN_VECT;
        if (pass_i) ctl_o.src = SRC_DIN;
      end
      OP_JUMP_RD: begin
        ctl_o.src = pass_i ? SRC_DIN : SRC_REG;
      end
      OP_RPT_STACK: begin
        if (!zero_i) begin
          ctl_o.src = SRC_TOS;
          ctl_o.cnt = CNT_DEC;
        end else begin
          ctl_o.stk = STK_POP;
        end
      end
      OP_RPT_DIN: begin
        if (!zero_i) begin
          ctl_o.src = SRC_DIN;
          ctl_o.cnt = CNT_DEC;
        end
      end
      OP_RETURN: begin
        if (pass_i) begin
          ctl_o.src = SRC_TOS;
          ctl_o.stk = STK_POP;
        end
      end
      OP_JUMP_POP: begin
        if (pass_i) begin
          ctl_o.src = SRC_DIN;
          ctl_o.stk = STK_POP;
        end
      end
      OP_LOAD_CNT: begin
        ctl_o.cnt = CNT_LOAD;
      end
      OP_TEST_END: begin
        if (pass_i) ctl_o.stk = STK_POP;
        else        ctl_o.src = SRC_TOS;
      end
      OP_NEXT: begin
        ctl_o.src = SRC_UPC;
      end
      OP_BRANCH3: begin
        if (pass_i) begin
          ctl_o.stk = STK_POP;
          if (!zero_i) ctl_o.cnt = CNT_DEC;
        end else if (!zero_i) begin
          ctl_o.src = SRC_TOS;
          ctl_o.cnt = CNT_DEC;
        end else begin
          ctl_o.src = SRC_DIN;
          ctl_o.stk = STK_POP;
        end
      end
      default: begin
        ctl_o.src = SRC_UPC;
      end
    endcase
  end

endmodule

// File: rtl/useq_regcnt.sv
`timescale 1ns/1ps
module useq_regcnt
  import useq_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  cnt_e         op_i,
  input  logic         force_load_n_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         zero_o
);

  function automatic logic [W-1:0] minus_one(input logic [W-1:0] v);
    return v - W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      q_o <= '0;
    end else if (!force_load_n_i) begin
      q_o <= d_i;
    end else begin
      case (op_i)
        CNT_LOAD: q_o <= d_i;
        CNT_DEC:  q_o <= minus_one(q_o);
        default:  q_o <= q_o;
      endcase
    end
  end

  assign zero_o = (q_o == '0);

endmodule

// File: rtl/useq_lifo.sv
`timescale 1ns/1ps
module useq_lifo
  import useq_pkg::*;
#(
  parameter int W     = 12,
  parameter int DEPTH = 9
) (
  input  logic                           clk,
  input  logic                           rst,
  input  stk_e                           op_i,
  input  logic [W-1:0]                   push_data_i,
  output logic [W-1:0]                   top_o,
  output logic                           full_o,
  output logic [$clog2(DEPTH+1)-1:0]     level_o
);

  localparam int DW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [DW-1:0] level_q;
  logic          empty;
  logic [IW-1:0] wr_idx;
  logic [IW-1:0] rd_idx;

  assign empty  = (level_q == '0);
  assign full_o = (level_q == DW'(DEPTH));
  // a push onto a full stack lands on the current top entry
  assign wr_idx = full_o ? IW'(DEPTH - 1) : IW'(level_q);
  assign rd_idx = empty ? '0 : IW'(level_q - DW'(1));

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (op_i == STK_PUSH && wr_idx == IW'(g)) begin
        mem[g] <= push_data_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '0;
    end else begin
      case (op_i)
        STK_CLEAR: level_q <= '0;
        STK_PUSH:  if (!full_o) level_q <= level_q + DW'(1);
        STK_POP:   if (!empty)  level_q <= level_q - DW'(1);
        default:   level_q <= level_q;
      endcase
    end
  end

  assign top_o   = mem[rd_idx];
  assign level_o = level_q;

endmodule

// File: rtl/useq_next_addr.sv
`timescale 1ns/1ps
module useq_next_addr
  import useq_pkg::*;
#(
  parameter int W     = 12,
  parameter int DEPTH = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   op,
  input  logic         cond_n,
  input  logic         cond_en_n,
  input  logic         reg_load_n,
  input  logic         out_en_n,
  input  logic         carry_in,
  input  logic [W-1:0] din,
  output logic [W-1:0] addr,
  output logic         addr_valid,
  output logic         full_n,
  output logic         pipe_en_n,
  output logic         map_en_n,
  output logic         vect_en_n
);

  localparam int DW = $clog2(DEPTH + 1);

  function automatic logic [W-1:0] upc_next(input logic [W-1:0] y, input logic cin);
    return y + W'(cin);
  endfunction

  // named internal events, observed by the bound checker
  logic          cond_ok;
  logic          cnt_zero;
  logic          push_evt;
  logic          pop_evt;
  logic [W-1:0]  upc_q;
  logic [W-1:0]  cnt_q;
  logic [W-1:0]  tos;
  logic [DW-1:0] depth_q;
  logic          stk_full;
  ctl_t          ctl;
  logic [NUM_EN-1:0] en_low;

  assign cond_ok = test_pass(cond_n, cond_en_n);

  useq_decode u_decode (
    .op_i   (op),
    .pass_i (cond_ok),
    .zero_i (cnt_zero),
    .ctl_o  (ctl)
  );

  useq_regcnt #(.W(W)) u_regcnt (
    .clk            (clk),
    .rst            (rst),
    .op_i           (ctl.cnt),
    .force_load_n_i (reg_load_n),
    .d_i            (din),
    .q_o            (cnt_q),
    .zero_o         (cnt_zero)
  );

  useq_lifo #(.W(W), .DEPTH(DEPTH)) u_lifo (
    .clk         (clk),
    .rst         (rst),
    .op_i        (ctl.stk),
    .push_data_i (upc_q),
    .top_o       (tos),
    .full_o      (stk_full),
    .level_o     (depth_q)
  );

  assign push_evt = (ctl.stk == STK_PUSH);
  assign pop_evt  = (ctl.stk == STK_POP);

  always_comb begin
    case (ctl.src)
      SRC_ZERO: addr = '0;
      SRC_DIN:  addr = din;
      SRC_REG:  addr = cnt_q;
      SRC_TOS:  addr = tos;
      default:  addr = upc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) upc_q <= '0;
    else     upc_q <= upc_next(addr, carry_in);
  end

  for (genvar e = 0; e < NUM_EN; e++) begin : g_en
    assign en_low[e] = (ctl.en != ensel_e'(e));
  end

  assign pipe_en_n  = en_low[int'(EN_PIPE)];
  assign map_en_n   = en_low[int'(EN_MAP)];
  assign vect_en_n  = en_low[int'(EN_VECT)];
  assign full_n     = ~stk_full;
  assign addr_valid = ~out_en_n;

endmodule

// File: rtl/useq_next_addr_chk.sv
`timescale 1ns/1ps
module useq_next_addr_chk #(
  parameter int W     = 12,
  parameter int DEPTH = 9
) (
  input logic                       clk,
  input logic                       rst,
  input logic [3:0]                 op,
  input logic                       reg_load_n,
  input logic                       carry_in,
  input logic [W-1:0]               din,
  input logic [W-1:0]               addr,
  input logic                       pipe_en_n,
  input logic                       map_en_n,
  input logic                       vect_en_n,
  input logic [W-1:0]               upc_q,
  input logic [W-1:0]               cnt_q,
  input logic [$clog2(DEPTH+1)-1:0] depth_q,
  input logic                       cnt_zero,
  input logic                       push_evt,
  input logic                       pop_evt
);

  assert_upc_follow_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (upc_q == ($past(addr) + W'($past(carry_in)))));

  assert_zero_code_R3: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd0) |-> (addr == '0 && !pipe_en_n));

  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    $countones({pipe_en_n, map_en_n, vect_en_n}) == 2);

  assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd0) |=> (depth_q == '0));

  assert_loop_dec_R6: assert property (@(posedge clk) disable iff (rst)
    ((op == 4'd8 || op == 4'd9) && reg_load_n && !cnt_zero) |=>
      (cnt_q == $past(cnt_q) - W'(1)));

  assert_load_override_R10: assert property (@(posedge clk) disable iff (rst)
    !reg_load_n |=> (cnt_q == $past(din)));

  assert_full_push_R11: assert property (@(posedge clk) disable iff (rst)
    (depth_q == DEPTH && push_evt) |=> (depth_q == DEPTH));

  assert_empty_pop_R11: assert property (@(posedge clk) disable iff (rst)
    (depth_q == '0 && pop_evt) |=> (depth_q == '0));

  assert_reset_R12: assert property (@(posedge clk)
    rst |=> (upc_q == '0 && cnt_q == '0 && depth_q == '0));

endmodule

bind useq_next_addr useq_next_addr_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .op         (op),
  .reg_load_n (reg_load_n),
  .carry_in   (carry_in),
  .din        (din),
  .addr       (addr),
  .pipe_en_n  (pipe_en_n),
  .map_en_n   (map_en_n),
  .vect_en_n  (vect_en_n),
  .upc_q      (upc_q),
  .cnt_q      (cnt_q),
  .depth_q    (depth_q),
  .cnt_zero   (cnt_zero),
  .push_evt   (push_evt),
  .pop_evt    (pop_evt)
);

// File: tb/useq_next_addr_tb.sv
`timescale 1ns/1ps
module useq_next_addr_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op = 4'd14;
  logic        cond_n = 1'b0;
  logic        cond_en_n = 1'b0;
  logic        reg_load_n = 1'b1;
  logic        out_en_n = 1'b0;
  logic        carry_in = 1'b1;
  logic [11:0] din = '0;
  logic [11:0] addr;
  logic        addr_valid, full_n, pipe_en_n, map_en_n, vect_en_n;

  int n_chk = 0;
  int n_fail = 0;
  logic cin_v = 1'b1;
  logic done = 1'b0;

  always #10 clk = ~clk;

  useq_next_addr u_dut (
    .clk(clk), .rst(rst), .op(op), .cond_n(cond_n), .cond_en_n(cond_en_n),
    .reg_load_n(reg_load_n), .out_en_n(out_en_n), .carry_in(carry_in), .din(din),
    .addr(addr), .addr_valid(addr_valid), .full_n(full_n),
    .pipe_en_n(pipe_en_n), .map_en_n(map_en_n), .vect_en_n(vect_en_n)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // one instruction cycle: drive after the falling edge, outputs settle before the rising edge
  task automatic cyc(input logic [3:0] o, input logic p, input logic [11:0] d);
    @(negedge clk);
    rst = 1'b0; op = o; cond_en_n = 1'b0; cond_n = ~p; din = d;
    reg_load_n = 1'b1; carry_in = cin_v; out_en_n = 1'b0;
    #4;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; op = 4'd14; reg_load_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    cyc(4'd14, 1'b0, 12'h0);
    chk("R12 counter after reset", addr, 0);
    chk("R12 stack not full after reset", full_n, 1);
    cyc(4'd12, 1'b0, 12'h077);
    cyc(4'd4, 1'b0, 12'h0);
    do_reset();
    cyc(4'd7, 1'b0, 12'h3FF);
    chk("R12 register cleared", addr, 0);
    cyc(4'd14, 1'b0, 12'h0);
    chk("R12 counter cleared mid-run", addr, 1);
  endtask

  task automatic t_continue();
    do_reset();
    cyc(4'd14, 1'b0, 0); chk("R8 continue 0", addr, 0);
    cyc(4'd14, 1'b0, 0); chk("R8 continue 1", addr, 1);
    cyc(4'd14, 1'b0, 0); chk("R2 increment", addr, 2);
    cin_v = 1'b0;
    cyc(4'd14, 1'b0, 0); chk("R2 carry low first", addr, 3);
    cyc(4'd14, 1'b0, 0); chk("R2 carry low repeats", addr, 3);
    cin_v = 1'b1;
    cyc(4'd14, 1'b0, 0); chk("R2 repeat last", addr, 3);
    cyc(4'd14, 1'b0, 0); chk("R2 resumes", addr, 4);
  endtask

  task automatic t_cond();
    do_reset();
    cyc(4'd3, 1'b0, 12'h0AB);
    cond_en_n = 1'b1; cond_n = 1'b1; #1;
    chk("R1 disabled test forces pass", addr, 12'h0AB);
    cond_en_n = 1'b0; cond_n = 1'b1; #1;
    chk("R1 enabled false fails", addr, 0);
    cond_en_n = 1'b0; cond_n = 1'b0; #1;
    chk("R1 enabled true passes", addr, 12'h0AB);
    cond_en_n = 1'b1; cond_n = 1'b0; #1;
    chk("R1 disabled true passes", addr, 12'h0AB);
  endtask

  task automatic t_strobes();
    do_reset();
    cyc(4'd2, 1'b0, 12'h2A5);
    chk("R3 map address", addr, 12'h2A5);
    chk("R3 map strobe", {pipe_en_n, map_en_n, vect_en_n}, 3'b101);
    cyc(4'd6, 1'b1, 12'h3C0);
    chk("R3 vector pass", addr, 12'h3C0);
    chk("R3 vector strobe", {pipe_en_n, map_en_n, vect_en_n}, 3'b110);
    cyc(4'd6, 1'b0, 12'h3C0);
    chk("R3 vector fail", addr, 12'h3C1);
    cyc(4'd0, 1'b0, 12'h555);
    chk("R3 zero code", addr, 0);
    chk("R3 pipe strobe", {pipe_en_n, map_en_n, vect_en_n}, 3'b011);
  endtask

  task automatic t_sub();
    do_reset();
    cyc(4'd14, 1'b0, 0);
    cyc(4'd4, 1'b0, 0);        chk("R5 push marker", addr, 1);
    cyc(4'd1, 1'b0, 12'h200);  chk("R4 call fail", addr, 2);
    cyc(4'd1, 1'b1, 12'h100);  chk("R4 call pass", addr, 12'h100);
    cyc(4'd14, 1'b0, 0);       chk("R8 in subroutine", addr, 12'h101);
    cyc(4'd10, 1'b0, 0);       chk("R7 return fail", addr, 12'h102);
    cyc(4'd10, 1'b1, 0);       chk("R7 return pass", addr, 3);
    cyc(4'd3, 1'b0, 12'h050);  chk("R4 jump fail", addr, 4);
    cyc(4'd3, 1'b1, 12'h050);  chk("R4 jump pass", addr, 12'h050);
    cyc(4'd11, 1'b0, 12'h060); chk("R7 jump-pop fail", addr, 12'h051);
    cyc(4'd11, 1'b1, 12'h060); chk("R7 jump-pop pass", addr, 12'h060);
    cyc(4'd4, 1'b0, 0);        chk("R5 push again", addr, 12'h061);
    cyc(4'd13, 1'b0, 0);       chk("R7 test-end fail loops", addr, 12'h061);
    cyc(4'd13, 1'b1, 0);       chk("R7 test-end pass exits", addr, 12'h062);
    cyc(4'd12, 1'b0, 12'h055); chk("R8 load count", addr, 12'h063);
    cyc(4'd7, 1'b0, 12'h070);  chk("R4 reg jump fail", addr, 12'h055);
    cyc(4'd7, 1'b1, 12'h070);  chk("R4 reg jump pass", addr, 12'h070);
    cyc(4'd5, 1'b0, 12'h080);  chk("R4 reg call fail", addr, 12'h055);
    cyc(4'd5, 1'b1, 12'h080);  chk("R4 reg call pass", addr, 12'h080);
    cyc(4'd10, 1'b1, 0);       chk("R4 second call pushed", addr, 12'h056);
    cyc(4'd10, 1'b1, 0);       chk("R4 first call pushed", addr, 12'h071);
  endtask

  task automatic t_push_load();
    do_reset();
    cyc(4'd12, 1'b0, 12'h010);
    cyc(4'd4, 1'b0, 12'h007);  chk("R5 push fail address", addr, 1);
    cyc(4'd7, 1'b0, 12'h3FF);  chk("R5 no load on fail", addr, 12'h010);
    cyc(4'd4, 1'b1, 12'h007);  chk("R5 push pass address", addr, 12'h011);
    cyc(4'd7, 1'b0, 12'h3FF);  chk("R5 load on pass", addr, 12'h007);
    cyc(4'd10, 1'b1, 0);       chk("R5 pushed on pass", addr, 12'h011);
    cyc(4'd10, 1'b1, 0);       chk("R5 pushed on fail", addr, 1);
  endtask

  task automatic t_loops();
    int n;
    do_reset();
    cyc(4'd14, 1'b0, 0);
    cyc(4'd4, 1'b0, 0);
    cyc(4'd4, 1'b1, 12'd2);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      cyc(4'd8, 1'b0, 0);
      if (addr == 12'd2) n++;
      else break;
    end
    chk("R14 stack loop N=2 runs N+1", n + 1, 3);
    chk("R6 stack loop exit address", addr, 3);
    cyc(4'd10, 1'b1, 0);       chk("R6 exit popped loop entry", addr, 1);
    cyc(4'd12, 1'b0, 12'd3);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      cyc(4'd9, 1'b0, 12'h040);
      if (addr == 12'h040) n++;
      else break;
    end
    chk("R14 din loop N=3 runs N+1", n + 1, 4);
    chk("R6 din loop exit address", addr, 12'h041);
    cyc(4'd7, 1'b0, 12'h3FF);  chk("R6 count ends at zero", addr, 0);
  endtask

  task automatic t_branch3();
    do_reset();
    cyc(4'd14, 1'b0, 0);
    cyc(4'd4, 1'b0, 0);
    cyc(4'd4, 1'b1, 12'd1);
    cyc(4'd15, 1'b0, 12'h300); chk("R9 fail nonzero to top", addr, 2);
    cyc(4'd15, 1'b0, 12'h300); chk("R9 fail zero to din", addr, 12'h300);
    cyc(4'd10, 1'b1, 0);       chk("R9 fail zero popped", addr, 1);
    cyc(4'd4, 1'b0, 0);
    cyc(4'd4, 1'b1, 12'd5);
    cyc(4'd15, 1'b1, 12'h300); chk("R9 pass to counter", addr, 4);
    cyc(4'd7, 1'b0, 12'h3FF);  chk("R9 pass decrements", addr, 4);
    cyc(4'd10, 1'b1, 0);       chk("R9 pass popped", addr, 2);
    cyc(4'd4, 1'b1, 12'd0);
    cyc(4'd15, 1'b1, 12'h300); chk("R9 pass zero to counter", addr, 4);
    cyc(4'd7, 1'b0, 12'h3FF);  chk("R9 zero count held", addr, 0);
  endtask

  task automatic t_override();
    do_reset();
    cyc(4'd12, 1'b0, 12'h020);
    cyc(4'd9, 1'b0, 12'h009);
    reg_load_n = 1'b0; #1;
    chk("R10 decrementing op address", addr, 12'h009);
    cyc(4'd7, 1'b0, 12'h3FF);  chk("R10 load beats decrement", addr, 12'h009);
    cyc(4'd14, 1'b0, 12'h123);
    reg_load_n = 1'b0; #1;
    cyc(4'd7, 1'b0, 12'h3FF);  chk("R10 load beats hold", addr, 12'h123);
  endtask

  task automatic t_stack();
    logic [11:0] pv [9];
    logic [11:0] pv10;
    do_reset();
    cyc(4'd10, 1'b1, 0);
    for (int i = 0; i < 9; i++) begin
      cyc(4'd4, 1'b0, 0);
      pv[i] = addr;
      chk("R11 not full below 9", full_n, 1);
    end
    cyc(4'd4, 1'b0, 0);
    pv10 = addr;
    chk("R11 full at 9 entries", full_n, 0);
    cyc(4'd10, 1'b1, 0);
    chk("R11 push on full overwrites top", addr, pv10);
    chk("R11 still full before pop", full_n, 0);
    cyc(4'd10, 1'b1, 0);
    chk("R11 entry below top intact", addr, pv[7]);
    chk("R11 not full after pop", full_n, 1);
    cyc(4'd4, 1'b0, 0);
    cyc(4'd4, 1'b0, 0);
    cyc(4'd0, 1'b0, 0);
    chk("R11 refilled to full", full_n, 0);
    cyc(4'd14, 1'b0, 0);
    chk("R3 zero code empties stack", full_n, 1);
  endtask

  task automatic t_valid();
    do_reset();
    cyc(4'd14, 1'b0, 0);
    chk("R13 valid with enable low", addr_valid, 1);
    out_en_n = 1'b1; #1;
    chk("R13 invalid with enable high", addr_valid, 0);
    chk("R13 address unaffected", addr, 0);
  endtask

  initial begin
    t_reset();
    t_continue();
    t_cond();
    t_strobes();
    t_sub();
    t_push_load();
    t_loops();
    t_branch3();
    t_override();
    t_stack();
    t_valid();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule